// File: doc/BRIEF.md
# Saturating Doubling Multiply-Subtract Vector Unit

This block is a fixed-width SIMD datapath. It takes two narrow-element source vectors and one wide-element accumulator vector, and it returns the updated accumulator. Each wide lane of the result depends only on the odd-indexed narrow element of the matching pair in each source. The unit multiplies those two signed elements and doubles the product. It clamps that value to the signed range of the wide lane. It then subtracts the clamped value from the accumulator lane and clamps the difference to the same range. Every lane is written, because the unit has no lane mask.

A two-bit size selector chooses the lane geometry. The reserved selector value produces no arithmetic. It raises an illegal-operation flag and returns the accumulator unmodified. Operands enter through a valid/ready handshake. The result is held in an output register until the consumer takes it. A sticky flag records that some lane clamped in either stage since the flag was last cleared.

Top module: `sdms_unit`

## Requirements
- R1: Wide lane e (bit offset e*2N) uses only narrow element 2e+1 of each source, at bits (2e+1)*N up to (2e+2)*N-1, where N is the narrow width. The even-indexed narrow elements have no effect on any output.
- R2: The intermediate value is 2*a*b of the two signed narrow elements, clamped to [-2^(2N-1), 2^(2N-1)-1]. This clamp engages exactly when both elements equal -2^(N-1).
- R3: The lane result is the accumulator lane minus the clamped product, clamped to the same wide signed range. The minimum and maximum accumulator values saturate toward the matching bound.
- R4: Size code 2'b01 gives 16-bit lanes from 8-bit elements. Code 2'b10 gives 32-bit lanes from 16-bit elements. Code 2'b11 gives 64-bit lanes from 32-bit elements. The lane count is VEC_W divided by the lane width, and every lane is written.
- R5: Size code 2'b00 is reserved. An accepted operation with this code sets illegal_op, returns acc_in unchanged on acc_out, and leaves sat_sticky unchanged. A legal operation clears illegal_op.
- R6: in_ready equals (not out_valid) or out_ready. An input is accepted on a clock edge where in_valid and in_ready are both high. Its result appears on acc_out with out_valid high right after that edge.
- R7: While out_valid is high and out_ready is low, out_valid stays high and acc_out and illegal_op stay stable.
- R8: sat_sticky is set after an accepted legal operation in which any lane clamped in either stage. It is cleared by sat_clear. When both occur on the same edge, the set wins.
- R9: After reset, out_valid, illegal_op, sat_sticky and acc_out are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set is present |
| in_ready | output | 1 | Unit can take an operand set |
| size_code | input | 2 | Lane geometry selector; 2'b00 reserved |
| src_a | input | VEC_W | First narrow-element source vector |
| src_b | input | VEC_W | Second narrow-element source vector |
| acc_in | input | VEC_W | Wide-element accumulator vector |
| out_valid | output | 1 | Result register holds an untaken result |
| out_ready | input | 1 | Consumer takes the result |
| acc_out | output | VEC_W | Updated accumulator vector |
| illegal_op | output | 1 | Held result came from the reserved size code |
| sat_sticky | output | 1 | Some lane clamped since the last clear |
| sat_clear | input | 1 | Clears sat_sticky |

## Verification
The assertions watch the behaviour that can be stated as a relation between cycles. They check that the result is held under back-pressure, that ready falls while a result waits, that the sticky flag keeps and loses its value correctly, and that the reserved code passes the accumulator through. Inside every lane, an assertion ties the first clamp to the case where both operands are the most negative value. The arithmetic values of each lane, and the fact that the even elements have no effect, can only be shown by the bench. It compares every lane for all three sizes against a wide-integer model. It also drives the most-negative squared products, accumulators at both bounds, and pairs of runs that differ only in their even elements.

// File: rtl/sdms_pkg.sv
package sdms_pkg;

    typedef enum logic [1:0] {
        SZ_RSVD = 2'b00,
        SZ_W16  = 2'b01,
        SZ_W32  = 2'b10,
        SZ_W64  = 2'b11
    } size_sel_e;

    localparam int NUM_GEOMS = 3;

    function automatic int narrow_width(input int base_w, input int geom);
        return base_w << (geom - 1);
    endfunction

endpackage

// File: rtl/sdms_lane.sv
module sdms_lane #(
    parameter int NW = 8
) (
    input  logic [NW-1:0]   op_a,
    input  logic [NW-1:0]   op_b,
    input  logic [2*NW-1:0] acc,
    output logic [2*NW-1:0] res,
    output logic            sat
);
    localparam int WW = 2 * NW;
    localparam logic [NW-1:0] NARROW_MIN = {1'b1, {(NW-1){1'b0}}};
    localparam logic [WW-1:0] WIDE_MAX   = {1'b0, {(WW-1){1'b1}}};
    localparam logic [WW-1:0] WIDE_MIN   = {1'b1, {(WW-1){1'b0}}};

    logic signed [WW-1:0] prod;
    logic [WW:0]          dbl;
    logic                 prod_sat;
    logic [WW-1:0]        prod_clamped;
    logic [WW:0]          diff;
    logic                 diff_sat;

    always_comb begin
        prod = $signed({{NW{op_a[NW-1]}}, op_a}) * $signed({{NW{op_b[NW-1]}}, op_b});
        dbl  = {prod, 1'b0};
        prod_sat = dbl[WW] ^ dbl[WW-1];
        if (prod_sat) begin
            prod_clamped = dbl[WW] ? WIDE_MIN : WIDE_MAX;
        end else begin
            prod_clamped = dbl[WW-1:0];
        end
    end

    always_comb begin
        diff = {acc[WW-1], acc} - {prod_clamped[WW-1], prod_clamped};
        diff_sat = diff[WW] ^ diff[WW-1];
        if (diff_sat) begin
            res = diff[WW] ? WIDE_MIN : WIDE_MAX;
        end else begin
            res = diff[WW-1:0];
        end
        sat = prod_sat | diff_sat;
    end

    always_comb begin
        if (!$isunknown({op_a, op_b})) begin
            // R2
            prod_clamp_chk: assert (prod_sat == ((op_a == NARROW_MIN) && (op_b == NARROW_MIN)));
        end
    end

endmodule

// File: rtl/sdms_bank.sv
module sdms_bank #(
    parameter int VEC_W = 128,
    parameter int NW    = 8
) (
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [VEC_W-1:0] acc_in,
    output logic [VEC_W-1:0] res,
    output logic             sat_any
);
    localparam int WW    = 2 * NW;
    localparam int LANES = VEC_W / WW;

    logic [LANES-1:0] lane_sat;
    logic [LANES-1:0] unused_even;

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        sdms_lane #(.NW(NW)) u_lane (
            .op_a (src_a[(2*e+1)*NW +: NW]),
            .op_b (src_b[(2*e+1)*NW +: NW]),
            .acc  (acc_in[e*WW +: WW]),
            .res  (res[e*WW +: WW]),
            .sat  (lane_sat[e])
        );
        assign unused_even[e] = (^src_a[2*e*NW +: NW]) ^ (^src_b[2*e*NW +: NW]);
    end

    assign sat_any = |lane_sat;

endmodule

// File: rtl/sdms_unit.sv
module sdms_unit
    import sdms_pkg::*;
#(
    parameter int VEC_W   = 128,
    parameter int BASE_NW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       size_code,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [VEC_W-1:0] acc_in,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VEC_W-1:0] acc_out,
    output logic             illegal_op,
    output logic             sat_sticky,
    input  logic             sat_clear
);
    typedef struct packed {
        logic             valid;
        logic             illegal;
        logic             sticky;
        logic [VEC_W-1:0] acc;
    } stage_t;

    stage_t st_d, st_q;

    logic [VEC_W-1:0] bank_res [1:NUM_GEOMS];
    logic [NUM_GEOMS:1] bank_sat;
    logic accept;
    logic new_sat;

    for (genvar k = 1; k <= NUM_GEOMS; k++) begin : g_bank
        localparam int NW = narrow_width(BASE_NW, k);
        sdms_bank #(.VEC_W(VEC_W), .NW(NW)) u_bank (
            .src_a   (src_a),
            .src_b   (src_b),
            .acc_in  (acc_in),
            .res     (bank_res[k]),
            .sat_any (bank_sat[k])
        );
    end

    assign in_ready = !st_q.valid || out_ready;
    assign accept   = in_valid && in_ready;

    always_comb begin
        st_d    = st_q;
        new_sat = 1'b0;
        if (out_ready) begin
            st_d.valid = 1'b0;
        end
        if (accept) begin
            st_d.valid = 1'b1;
            case (size_sel_e'(size_code))
                SZ_W16: begin
                    st_d.illegal = 1'b0;
                    st_d.acc     = bank_res[1];
                    new_sat      = bank_sat[1];
                end
                SZ_W32: begin
                    st_d.illegal = 1'b0;
                    st_d.acc     = bank_res[2];
                    new_sat      = bank_sat[2];
                end
                SZ_W64: begin
                    st_d.illegal = 1'b0;
                    st_d.acc     = bank_res[3];
                    new_sat      = bank_sat[3];
                end
                default: begin
                    st_d.illegal = 1'b1;
                    st_d.acc     = acc_in;
                end
            endcase
        end
        if (sat_clear) begin
            st_d.sticky = 1'b0;
        end
        if (new_sat) begin
            st_d.sticky = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign acc_out    = st_q.acc;
    assign illegal_op = st_q.illegal;
    assign sat_sticky = st_q.sticky;

    // R7
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(acc_out) && $stable(illegal_op)));

    // R6
    ready_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R5
    reserved_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && size_code == 2'b00) |=> (illegal_op && acc_out == $past(acc_in)));

    // R8
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_sticky && !sat_clear) |=> sat_sticky);

    // R8
    sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_clear && !(in_valid && in_ready)) |=> !sat_sticky);

endmodule

// File: tb/sdms_unit_tb.sv
module sdms_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int VW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [1:0]    size_code = 2'b01;
    logic [VW-1:0] src_a = '0, src_b = '0, acc_in = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [VW-1:0] acc_out;
    logic          illegal_op, sat_sticky;
    logic          sat_clear = 1'b0;

    int checks = 0;
    int failures = 0;
    bit exp_sticky = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdms_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .size_code(size_code), .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
        .out_valid(out_valid), .out_ready(out_ready), .acc_out(acc_out),
        .illegal_op(illegal_op), .sat_sticky(sat_sticky), .sat_clear(sat_clear)
    );

    task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic signed [135:0] sx(input logic [VW-1:0] v, input int pos, input int w);
        logic signed [135:0] t;
        t = $signed({8'b0, v >> pos});
        t = t & ((136'sd1 <<< w) - 136'sd1);
        if (t[w-1]) t = t - (136'sd1 <<< w);
        return t;
    endfunction

    function automatic void model(input logic [1:0] s, input logic [VW-1:0] a, input logic [VW-1:0] b,
                                  input logic [VW-1:0] c, output logic [VW-1:0] r, output bit sat);
        int nw, lw, ln;
        logic signed [135:0] ea, eb, ec, p, d, mx, mn;
        logic [VW-1:0] lmask;
        r = '0;
        sat = 1'b0;
        if (s == 2'b00) begin
            r = c;
            return;
        end
        nw = 4 << s;
        lw = 2 * nw;
        ln = VW / lw;
        mx = (136'sd1 <<< (lw-1)) - 136'sd1;
        mn = -(136'sd1 <<< (lw-1));
        lmask = (128'd1 << lw) - 128'd1;
        for (int e = 0; e < ln; e++) begin
            ea = sx(a, (2*e+1)*nw, nw);
            eb = sx(b, (2*e+1)*nw, nw);
            ec = sx(c, e*lw, lw);
            p = 136'sd2 * ea * eb;
            if (p > mx) begin p = mx; sat = 1'b1; end
            else if (p < mn) begin p = mn; sat = 1'b1; end
            d = ec - p;
            if (d > mx) begin d = mx; sat = 1'b1; end
            else if (d < mn) begin d = mn; sat = 1'b1; end
            r = r | ((d[VW-1:0] & lmask) << (e*lw));
        end
    endfunction

    function automatic logic [VW-1:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    // Vector with value odd_v in every odd narrow element and even_v in every even one
    function automatic logic [VW-1:0] fill_narrow(input logic [1:0] s, input logic [63:0] odd_v, input logic [63:0] even_v);
        int nw;
        logic [VW-1:0] v, m;
        nw = 4 << s;
        m = (128'd1 << nw) - 128'd1;
        v = '0;
        for (int i = 0; i < VW/nw; i++)
            v = v | ((((i % 2) == 1 ? {64'd0, odd_v} : {64'd0, even_v}) & m) << (i*nw));
        return v;
    endfunction

    function automatic logic [VW-1:0] fill_wide(input logic [1:0] s, input logic [63:0] val);
        int lw;
        logic [VW-1:0] v, m;
        lw = 8 << s;
        m = (128'd1 << lw) - 128'd1;
        v = '0;
        for (int i = 0; i < VW/lw; i++) v = v | (({64'd0, val} & m) << (i*lw));
        return v;
    endfunction

    task automatic run_op(input logic [1:0] s, input logic [VW-1:0] a, input logic [VW-1:0] b,
                          input logic [VW-1:0] c, input string req, output logic [VW-1:0] got);
        logic [VW-1:0] er;
        bit es;
        model(s, a, b, c, er, es);
        @(negedge clk);
        in_valid = 1'b1; size_code = s; src_a = a; src_b = b; acc_in = c;
        @(negedge clk);
        in_valid = 1'b0;
        if (s != 2'b00 && es) exp_sticky = 1'b1;
        got = acc_out;
        chk(out_valid == 1'b1, {req, " out_valid"}, {127'd0, out_valid}, 128'd1);
        chk(acc_out == er, {req, " acc_out"}, acc_out, er);
        chk(illegal_op == (s == 2'b00), {req, " illegal_op"}, {127'd0, illegal_op}, {127'd0, s == 2'b00});
        chk(sat_sticky == exp_sticky, {req, " R8 sticky"}, {127'd0, sat_sticky}, {127'd0, exp_sticky});
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R9 out_valid", {127'd0, out_valid}, '0);
        chk(acc_out == '0, "R9 acc_out", acc_out, '0);
        chk(illegal_op == 1'b0 && sat_sticky == 1'b0, "R9 flags", {126'd0, illegal_op, sat_sticky}, '0);
        chk(in_ready == 1'b1, "R6 ready after reset", {127'd0, in_ready}, 128'd1);
    endtask

    task automatic clear_sticky();
        @(negedge clk); sat_clear = 1'b1;
        @(negedge clk); sat_clear = 1'b0;
        exp_sticky = 1'b0;
        chk(sat_sticky == 1'b0, "R8 cleared", {127'd0, sat_sticky}, '0);
    endtask

    task automatic t_random_sizes();
        logic [VW-1:0] g;
        for (int s = 1; s <= 3; s++)
            for (int n = 0; n < 6; n++)
                run_op(2'(s), rnd128(), rnd128(), rnd128(), "R4 R3 random lanes", g);
    endtask

    task automatic t_odd_only();
        logic [VW-1:0] a, b, c, a2, b2, g1, g2, em;
        for (int s = 1; s <= 3; s++) begin
            a = rnd128(); b = rnd128(); c = rnd128();
            em = fill_narrow(2'(s), 64'd0, 64'hFFFF_FFFF_FFFF_FFFF);
            a2 = a ^ (rnd128() & em);
            b2 = b ^ (rnd128() & em);
            run_op(2'(s), a, b, c, "R1 base", g1);
            run_op(2'(s), a2, b2, c, "R1 even changed", g2);
            chk(g1 == g2, "R1 even elements ignored", g2, g1);
        end
    endtask

    task automatic t_corners();
        logic [VW-1:0] g;
        logic [63:0] nmin, nmax, wmin, wmax;
        for (int s = 1; s <= 3; s++) begin
            nmin = 64'd1 << ((4 << s) - 1);
            nmax = nmin - 64'd1;
            wmin = 64'd1 << ((8 << s) - 1);
            wmax = wmin - 64'd1;
            clear_sticky();
            run_op(2'(s), fill_narrow(2'(s), nmin, 64'd0), fill_narrow(2'(s), nmin, 64'd0),
                   '0, "R2 min*min clamps", g);
            chk(sat_sticky == 1'b1, "R2 min*min sets sticky", {127'd0, sat_sticky}, 128'd1);
            clear_sticky();
            run_op(2'(s), fill_narrow(2'(s), nmin, nmin), fill_narrow(2'(s), nmax, nmin),
                   '0, "R2 min*max no clamp", g);
            chk(sat_sticky == 1'b0, "R2 no clamp keeps sticky low", {127'd0, sat_sticky}, '0);
            run_op(2'(s), fill_narrow(2'(s), 64'd3, 64'd0), fill_narrow(2'(s), 64'd5, 64'd0),
                   fill_wide(2'(s), wmin), "R3 acc at min", g);
            clear_sticky();
            run_op(2'(s), fill_narrow(2'(s), nmin, 64'd0), fill_narrow(2'(s), nmax, 64'd0),
                   fill_wide(2'(s), wmax), "R3 acc at max", g);
            run_op(2'(s), fill_narrow(2'(s), nmin, 64'd0), fill_narrow(2'(s), nmin, 64'd0),
                   fill_wide(2'(s), wmin), "R3 min acc minus clamped", g);
        end
    endtask

    task automatic t_reserved();
        logic [VW-1:0] g, c;
        clear_sticky();
        c = rnd128();
        run_op(2'b00, fill_narrow(2'b01, 64'h80, 64'h80), fill_narrow(2'b01, 64'h80, 64'h80),
               c, "R5 reserved code", g);
        chk(sat_sticky == 1'b0, "R5 reserved leaves sticky", {127'd0, sat_sticky}, '0);
        run_op(2'b01, '0, '0, c, "R5 legal after reserved clears illegal", g);
    endtask

    task automatic t_backpressure();
        logic [VW-1:0] a1, b1, c1, a2, b2, c2, e1, e2;
        bit s1, s2;
        a1 = rnd128(); b1 = rnd128(); c1 = rnd128();
        a2 = rnd128(); b2 = rnd128(); c2 = rnd128();
        model(2'b10, a1, b1, c1, e1, s1);
        model(2'b11, a2, b2, c2, e2, s2);
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; size_code = 2'b10; src_a = a1; src_b = b1; acc_in = c1;
        @(negedge clk);
        size_code = 2'b11; src_a = a2; src_b = b2; acc_in = c2;
        chk(in_ready == 1'b0, "R6 ready low while held", {127'd0, in_ready}, '0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b1 && acc_out == e1, "R7 result held", acc_out, e1);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1 && acc_out == e2, "R6 accepted on release", acc_out, e2);
        if (s1 || s2) exp_sticky = 1'b1;
        chk(sat_sticky == exp_sticky, "R8 sticky after stall", {127'd0, sat_sticky}, {127'd0, exp_sticky});
        @(negedge clk);
        chk(out_valid == 1'b0, "R6 valid drops after take", {127'd0, out_valid}, '0);
    endtask

    task automatic t_clear_vs_set();
        logic [VW-1:0] g;
        exp_sticky = 1'b0;
        @(negedge clk);
        sat_clear = 1'b1;
        in_valid = 1'b1; size_code = 2'b01;
        src_a = fill_narrow(2'b01, 64'h80, 64'd0); src_b = src_a; acc_in = '0;
        @(negedge clk);
        sat_clear = 1'b0; in_valid = 1'b0;
        chk(sat_sticky == 1'b1, "R8 set wins over clear", {127'd0, sat_sticky}, 128'd1);
        clear_sticky();
        run_op(2'b01, '0, '0, '0, "R8 zero op", g);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_random_sizes();
        t_odd_only();
        t_corners();
        t_reserved();
        t_backpressure();
        t_clear_vs_set();
        finish_run();
    end

endmodule